// File: doc/BRIEF.md
# Composite Clock AMI Decoder

This block recovers frame and superframe timing from a composite timing signal that arrives as alternate-mark-inverted line samples. A line interface supplies one sample of its positive-pulse and negative-pulse lines per 64 kHz bit period, qualified by `bit_valid`. The composite signal is all marks. Every eighth mark repeats the polarity of the previous mark, and that repeat is a bipolar violation. The decoder detects these violations and locks to their eight-bit spacing. It then emits one 8 kHz pulse per frame.

With `mode_400` high, the decoder also accepts the superframe format, in which one violation in every twenty is left out. The first missing violation after lock sets the superframe phase. From then on the decoder emits one 400 Hz pulse per superframe and flags a missing violation at any other slot. Violations at unexpected positions, loss of signal and loss of lock are reported on plain status pins.

The sample input has no back-pressure. The decoder accepts a sample on every clock where `bit_valid` is high, and the source may space samples by any number of idle clocks. Each output pulse lasts exactly one clock and follows its sample by one clock.

Top module: `cc_ami_decoder`

## Requirements
- R1: A sample is a mark when exactly one of `line_pos` or `line_neg` is high; its polarity is positive when `line_pos` is high. A sample with both lines low or both high is empty. A violation is a mark whose polarity equals that of the previous mark.
- R2: `clk64_en` is high for exactly the one clock that follows each clock with `bit_valid` high, and low otherwise.
- R3: From reset the decoder hunts. It locks on the second of two violations that are exactly 8 samples apart, and `locked` is high from the clock after that sample.
- R4: While locked, `pulse_8k` fires one clock after every expected violation slot, which falls 8 samples after the previous one. It also fires after the violation that completes the lock.
- R5: While locked, a violation at any sample other than the expected slot raises `slip_flag` for one clock. It does not move the frame phase.
- R6: With `mode_400` low, a locked decoder that finds no violation at an expected slot raises `miss_flag` for one clock.
- R7: With `mode_400` high, the first missing violation after lock aligns the superframe and fires `pulse_400`. From then on a missing violation is expected exactly once every 20 frames, and each such miss fires `pulse_400`. A miss at any other slot, or a violation present where a miss is due, raises `miss_flag` without shifting the superframe count.
- R8: Timing errors (R5, R6, R7) that follow each other with no correct expected slot between them drop the decoder back to hunting on the third such error. A correct expected slot clears the error run.
- R9: `los` is high out of reset and is set by any empty sample. It clears after 8 consecutive mark samples.
- R10: After reset, `locked`, `clk64_en`, `pulse_8k`, `pulse_400`, `slip_flag` and `miss_flag` are low and `los` is high.
- R11: While hunting, no `pulse_8k`, `pulse_400`, `slip_flag` or `miss_flag` is produced, except the `pulse_8k` of R4 that completes the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | One sample per 64 kHz bit period |
| line_pos | input | 1 | Positive-pulse line sample |
| line_neg | input | 1 | Negative-pulse line sample |
| mode_400 | input | 1 | High selects the 20-frame superframe format |
| clk64_en | output | 1 | Bit-rate clock enable |
| pulse_8k | output | 1 | Frame pulse |
| pulse_400 | output | 1 | Superframe pulse |
| locked | output | 1 | Frame timing locked |
| slip_flag | output | 1 | Violation off the expected slot |
| miss_flag | output | 1 | Missing-violation pattern error |
| los | output | 1 | Loss of signal |

## Verification
The bench builds the decoder with its default parameters: 8-bit frames, 20-frame superframes, a limit of 3 errors and a clearing run of 8 marks. With these values one superframe is 160 samples. Three superframe alignments, a slip, an unlock followed by relock, and a full loss-of-signal clearing run therefore each fit within a few hundred samples. Each sample is checked against the position of its frame and superframe, so both formats can be fed in either mode.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic {
    SYNC_HUNT = 1'b0,
    SYNC_LOCK = 1'b1
  } sync_e;
endpackage

// File: rtl/cc_mark_decode.sv
module cc_mark_decode #(
  parameter int LOS_CLEAR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic pos_in,
  input  logic neg_in,
  output logic viol,
  output logic los
);
  localparam int CW = (LOS_CLEAR > 2) ? $clog2(LOS_CLEAR) : 1;
  localparam logic [CW-1:0] CMAX = CW'(LOS_CLEAR - 1);

  logic          is_mark;
  logic          have_prev;
  logic          prev_pos;
  logic [CW-1:0] run_cnt;

  assign is_mark = pos_in ^ neg_in;
  assign viol    = smp_valid && is_mark && have_prev && (pos_in == prev_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_pos  <= 1'b0;
      run_cnt   <= '0;
      los       <= 1'b1;
    end else if (smp_valid) begin
      if (is_mark) begin
        have_prev <= 1'b1;
        prev_pos  <= pos_in;
        if (run_cnt == CMAX) los <= 1'b0;
        else                 run_cnt <= run_cnt + 1'b1;
      end else begin
        los     <= 1'b1;
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/cc_frame_track.sv
module cc_frame_track
  import cc_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int SF_FRAMES  = 20,
  parameter int ERR_LIMIT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic viol,
  input  logic mode_400,
  output logic locked,
  output logic pulse_8k,
  output logic pulse_400,
  output logic slip_flag,
  output logic miss_flag
);
  localparam int PW = $clog2(FRAME_BITS);
  localparam int GW = PW + 1;
  localparam int FW = $clog2(SF_FRAMES);
  localparam int EW = $clog2(ERR_LIMIT + 1);
  localparam logic [PW-1:0] LAST_BIT = PW'(FRAME_BITS - 1);
  localparam logic [GW-1:0] GAP_HIT  = GW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] LAST_FRM = FW'(SF_FRAMES - 1);
  localparam logic [EW-1:0] ERR_TOP  = EW'(ERR_LIMIT - 1);

  sync_e         state;
  logic [PW-1:0] phase;
  logic [GW-1:0] gap;
  logic          seen;
  logic [FW-1:0] frm;
  logic          aligned;
  logic [EW-1:0] err_run;

  logic in_lock, at_slot, lock_now, drop_due, drop_ok, slot_good, t_err, unlock;

  always_comb begin
    in_lock  = (state == SYNC_LOCK);
    at_slot  = (phase == LAST_BIT);
    lock_now = smp_valid && !in_lock && viol && seen && (gap == GAP_HIT);
    drop_due = aligned && (frm == LAST_FRM);
    drop_ok  = mode_400 && !viol && (!aligned || drop_due);
    if (!mode_400)  slot_good = viol;
    else if (viol)  slot_good = !drop_due;
    else            slot_good = drop_ok;
    t_err  = smp_valid && in_lock && (at_slot ? !slot_good : viol);
    unlock = t_err && (err_run == ERR_TOP);
  end

  assign locked = in_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SYNC_HUNT;
      phase   <= '0;
      gap     <= '0;
      seen    <= 1'b0;
      frm     <= '0;
      aligned <= 1'b0;
      err_run <= '0;
    end else if (smp_valid) begin
      phase <= (lock_now || at_slot) ? '0 : phase + 1'b1;
      if (!in_lock) begin
        gap  <= viol ? '0 : ((&gap) ? gap : gap + 1'b1);
        seen <= seen | viol;
        if (lock_now) begin
          state   <= SYNC_LOCK;
          err_run <= '0;
          frm     <= '0;
          aligned <= 1'b0;
        end
      end else begin
        if (unlock) begin
          state <= SYNC_HUNT;
          seen  <= 1'b0;
          gap   <= '0;
        end
        if (t_err)        err_run <= err_run + 1'b1;
        else if (at_slot) err_run <= '0;
        if (at_slot) begin
          if (!mode_400) begin
            frm     <= '0;
            aligned <= 1'b0;
          end else if (drop_ok) begin
            frm     <= '0;
            aligned <= 1'b1;
          end else begin
            frm <= (frm == LAST_FRM) ? '0 : frm + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_8k  <= 1'b0;
      pulse_400 <= 1'b0;
      slip_flag <= 1'b0;
      miss_flag <= 1'b0;
    end else begin
      pulse_8k  <= lock_now || (smp_valid && in_lock && at_slot && !unlock);
      pulse_400 <= smp_valid && in_lock && at_slot && drop_ok;
      slip_flag <= smp_valid && in_lock && !at_slot && viol;
      miss_flag <= smp_valid && in_lock && at_slot && !slot_good;
    end
  end
endmodule

// File: rtl/cc_ami_decoder.sv
module cc_ami_decoder
  import cc_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int SF_FRAMES  = 20,
  parameter int ERR_LIMIT  = 3,
  parameter int LOS_CLEAR  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic line_pos,
  input  logic line_neg,
  input  logic mode_400,
  output logic clk64_en,
  output logic pulse_8k,
  output logic pulse_400,
  output logic locked,
  output logic slip_flag,
  output logic miss_flag,
  output logic los
);
  logic viol_w;

  cc_mark_decode #(
    .LOS_CLEAR(LOS_CLEAR)
  ) u_mark (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(bit_valid),
    .pos_in   (line_pos),
    .neg_in   (line_neg),
    .viol     (viol_w),
    .los      (los)
  );

  cc_frame_track #(
    .FRAME_BITS(FRAME_BITS),
    .SF_FRAMES (SF_FRAMES),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(bit_valid),
    .viol     (viol_w),
    .mode_400 (mode_400),
    .locked   (locked),
    .pulse_8k (pulse_8k),
    .pulse_400(pulse_400),
    .slip_flag(slip_flag),
    .miss_flag(miss_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk64_en <= 1'b0;
    else        clk64_en <= bit_valid;
  end
endmodule

// File: rtl/cc_ami_decoder_chk.sv
module cc_ami_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic clk64_en,
  input logic pulse_8k,
  input logic pulse_400,
  input logic locked,
  input logic slip_flag,
  input logic miss_flag,
  input logic los
);
  assert_en_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> clk64_en);
  assert_en_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !clk64_en);
  assert_lock_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> pulse_8k);
  assert_frame_when_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_8k |-> locked);
  assert_slip_off_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(slip_flag && pulse_8k));
  assert_miss_on_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_flag |-> (pulse_8k || !locked));
  assert_super_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_400 |-> pulse_8k);
  assert_unlock_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (slip_flag || miss_flag));
  assert_los_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(bit_valid));
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !(pulse_8k || pulse_400 || slip_flag || miss_flag));
endmodule

bind cc_ami_decoder cc_ami_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_valid(bit_valid),
  .clk64_en (clk64_en),
  .pulse_8k (pulse_8k),
  .pulse_400(pulse_400),
  .locked   (locked),
  .slip_flag(slip_flag),
  .miss_flag(miss_flag),
  .los      (los)
);

// File: tb/cc_ami_decoder_bench.sv
module cc_ami_decoder_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        m400;
    logic        drops;
    logic [15:0] frames;
  } scen_t;

  localparam scen_t SCEN [4] = '{
    '{1'b0, 1'b0, 16'd40},
    '{1'b1, 1'b1, 16'd60},
    '{1'b0, 1'b1, 16'd30},
    '{1'b1, 1'b0, 16'd24}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic line_pos = 1'b0;
  logic line_neg = 1'b0;
  logic mode_400 = 1'b0;
  logic clk64_en, pulse_8k, pulse_400, locked, slip_flag, miss_flag, los;

  int checks = 0;
  int errors = 0;
  bit last_p = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_ami_decoder u_cc_ami_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_valid(bit_valid),
    .line_pos (line_pos),
    .line_neg (line_neg),
    .mode_400 (mode_400),
    .clk64_en (clk64_en),
    .pulse_8k (pulse_8k),
    .pulse_400(pulse_400),
    .locked   (locked),
    .slip_flag(slip_flag),
    .miss_flag(miss_flag),
    .los      (los)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0;
    bit_valid = 1'b0;
    mode_400 = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_p = 1'b0;
  endtask

  task automatic send_raw(input bit p, input bit n);
    @(negedge clk);
    bit_valid = 1'b1;
    line_pos = p;
    line_neg = n;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_sym(input bit v);
    bit p;
    p = v ? last_p : !last_p;
    last_p = p;
    send_raw(p, !p);
  endtask

  function automatic bit due(input int i, input bit drops);
    return (i % 8 == 7) && !(drops && ((i / 8) % 20 == 19));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Table of clean streams in both formats and both modes
    for (int s = 0; s < 4; s++) begin
      do_reset(SCEN[s].m400);
      chk("R10 locked after reset", locked, 0);
      chk("R10 los after reset", los, 1);
      chk("R10 pulse_8k after reset", pulse_8k, 0);
      chk("R10 clk64_en after reset", clk64_en, 0);
      for (int i = 0; i < int'(SCEN[s].frames) * 8; i++) begin
        bit slot, sfb;
        slot = (i % 8 == 7);
        sfb  = slot && ((i / 8) % 20 == 19);
        send_sym(due(i, SCEN[s].drops));
        chk("R2 clk64_en", clk64_en, 1);
        chk("R3 locked", locked, int'(i >= 15));
        chk("R4 pulse_8k", pulse_8k, int'(slot && i >= 15));
        chk("R7 pulse_400", pulse_400, int'(SCEN[s].m400 && SCEN[s].drops && sfb));
        chk("R6 miss_flag", miss_flag, int'(!SCEN[s].m400 && SCEN[s].drops && sfb));
        chk("R5 slip_flag clean", slip_flag, 0);
        chk("R9 los", los, int'(i < 7));
      end
    end

    // R5: stray violation while locked
    do_reset(1'b0);
    for (int i = 0; i < 96; i++) begin
      send_sym(due(i, 1'b0) || i == 83);
      if (i == 83) begin
        chk("R5 slip at stray violation", slip_flag, 1);
        chk("R5 still locked", locked, 1);
      end
      if (i == 87) begin
        chk("R5 frame phase kept", pulse_8k, 1);
        chk("R5 no miss", miss_flag, 0);
        chk("R5 locked at slot", locked, 1);
      end
    end

    // R8 / R11: three errors in a row, then relock
    do_reset(1'b0);
    for (int i = 0; i < 100; i++) begin
      send_sym(due(i, 1'b0) || (i >= 81 && i <= 83));
      if (i == 81) chk("R8 slip one", slip_flag, 1);
      if (i == 82) chk("R8 locked after two errors", locked, 1);
      if (i == 83) chk("R8 hunting after three errors", locked, 0);
      if (i == 87) chk("R11 no frame pulse while hunting", pulse_8k, 0);
      if (i == 94) chk("R3 not yet relocked", locked, 0);
      if (i == 95) begin
        chk("R3 relocked", locked, 1);
        chk("R4 lock frame pulse", pulse_8k, 1);
      end
    end

    // R9 / R1: empty periods and both-high samples
    do_reset(1'b0);
    for (int i = 0; i < 112; i++) begin
      if (i == 85)       send_raw(1'b0, 1'b0);
      else if (i == 100) send_raw(1'b1, 1'b1);
      else               send_sym(due(i, 1'b0));
      if (i == 85) chk("R9 los on empty", los, 1);
      if (i == 87) begin
        chk("R1 empty keeps polarity chain", pulse_8k, 1);
        chk("R1 empty no miss", miss_flag, 0);
      end
      if (i == 92) chk("R9 los held at seven marks", los, 1);
      if (i == 93) chk("R9 los cleared at eight marks", los, 0);
      if (i == 100) chk("R1 both high is empty", los, 1);
      if (i == 103) chk("R1 lock kept", locked, 1);
    end

    // R7: miss at a wrong frame keeps the superframe wheel
    do_reset(1'b1);
    for (int i = 0; i < 480; i++) begin
      send_sym(due(i, 1'b1) && i != 367);
      if (i == 319) chk("R7 second superframe", pulse_400, 1);
      if (i == 367) begin
        chk("R7 wrong-slot miss flagged", miss_flag, 1);
        chk("R7 wrong-slot no pulse_400", pulse_400, 0);
        chk("R7 locked after one miss", locked, 1);
      end
      if (i == 479) begin
        chk("R7 wheel kept", pulse_400, 1);
        chk("R7 due miss clean", miss_flag, 0);
      end
    end

    // R7: violation present where a miss is due
    do_reset(1'b1);
    for (int i = 0; i < 480; i++) begin
      send_sym(due(i, 1'b1) || i == 479);
      if (i == 479) begin
        chk("R7 present at due slot flagged", miss_flag, 1);
        chk("R7 present at due slot no pulse", pulse_400, 0);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule